// File: doc/BRIEF.md
# Serial Flash Command Framing Unit

This block is the slave-side front end of a serial NOR flash. It watches the serial clock, the active-low chip select and the serial data input. All three are brought into the block's own clock domain through a short synchronizer, so every rule below is counted in serial-clock edges. In each frame the block assembles a one-byte opcode, and after it any address, dummy or data bytes, all most significant bit first. It sorts the opcode into one of two classes. A read-class command moves on to a data-out phase. In that phase the block takes bytes from an external source and shifts them out on one or two output lines. A modify-class command is only staged while the frame is open. When chip select rises, the block either commits it through a single strobe, or drops it if the frame did not end on a byte boundary.

A busy input marks an internal status-write, program or erase cycle. While it is high, opcodes that touch the memory array are parked in an ignore state for the rest of the frame. They produce no output and no strobe, and the ongoing cycle is not disturbed. Status and control opcodes still run. The memory array, the cycle timing and the lock registers sit outside this block.

The controller has seven states:
- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: the first byte is being collected.
- `ST_ADDR`: address bytes are being collected.
- `ST_DUMMY`: one dummy byte is being collected.
- `ST_RDATA`: data is being shifted out.
- `ST_WDATA`: data bytes of a modify command are being collected, or extra bytes after one are being absorbed.
- `ST_IGNORE`: an unknown or blocked opcode is waiting for the end of the frame.

Transitions:
- `ST_IDLE` to `ST_OPCODE` when chip select falls.
- `ST_OPCODE` to `ST_IGNORE` when the opcode is unknown, or when it targets the array while busy is high.
- `ST_OPCODE` to `ST_ADDR` when the opcode carries an address.
- `ST_OPCODE` to `ST_RDATA` for a read with no address.
- `ST_OPCODE` to `ST_WDATA` for a modify command with no address.
- `ST_ADDR` to `ST_DUMMY`, `ST_RDATA` or `ST_WDATA` after the last address byte, depending on the opcode.
- `ST_DUMMY` to `ST_RDATA` after the dummy byte.
- Any state to `ST_IDLE` when chip select rises.

Top module: `spi_cmd_frontend`

## Requirements
- R1: Every opcode, address and data byte is taken most significant bit first. Each bit is sampled on a rising serial-clock edge, starting with the first rising edge after chip select falls.
- R2: For a read-class opcode, output bits appear on `dq1_out` most significant bit first. Each bit changes after a falling serial-clock edge. `dq1_oe` is 1 only during the data-out phase and is 0 again after chip select rises. Each output byte is taken from `rd_data`, and `rd_take` pulses once at the moment it is taken.
- R3: Opcode 0x3B (dual-output read) shifts out two bits per clock. `dq1_out` carries bits 7, 5, 3 and 1 in turn, and `dq0_out` carries bits 6, 4, 2 and 0. `dq0_oe` is 1 only in this mode.
- R4: These opcodes take three address bytes: 0x03, 0x0B, 0x3B, 0x02, 0x20 and 0xD8. Opcodes 0x0B and 0x3B also take one dummy byte before data-out begins.
- R5: A read-class frame may be ended after any bit without a strobe. The next frame decodes normally.
- R6: A modify-class opcode gives one `cmd_commit` pulse after chip select rises, with `cmd_op`, `cmd_addr` and `cmd_len`. This happens only if the opcode and all of its address bytes have arrived, and the count of rising clock edges in the frame is a multiple of eight. The modify-class opcodes are 0x01, 0x02, 0x04, 0x06, 0x20, 0xD8, 0xC7 and 0xB9. The read-class opcodes are 0x03, 0x0B, 0x3B, 0x05, 0x9F and 0xAB.
- R7: A modify-class frame whose chip select rises mid-byte produces no strobe. The next frame still commits normally.
- R8: Every whole byte that follows the opcode and address of a modify command pulses `dat_valid` with `dat_byte`. `cmd_len` equals their count, saturating at its maximum.
- R9: While `busy` is 1 when the opcode completes, the array opcodes (0x03, 0x0B, 0x3B, 0x02, 0x20, 0xD8, 0xC7) produce neither output enable nor strobe. Opcodes 0x05 and 0x06 still work.
- R10: An unknown opcode is ignored until chip select rises, whatever bytes follow it.
- R11: After reset, `dq1_oe`, `dq0_oe`, `cmd_commit`, `rd_take` and `dat_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock, oversamples the serial lines |
| rst_n | input | 1 | active-low asynchronous reset |
| sck | input | 1 | serial clock from the master |
| cs_n | input | 1 | active-low chip select |
| dq0_in | input | 1 | serial data into the block |
| dq0_out | output | 1 | low-order output bit in dual-output mode |
| dq0_oe | output | 1 | drive enable for dq0_out |
| dq1_out | output | 1 | serial data out |
| dq1_oe | output | 1 | drive enable for dq1_out, high impedance when 0 |
| busy | input | 1 | internal write or erase cycle in progress |
| rd_data | input | 8 | byte to be shifted out next |
| rd_take | output | 1 | pulse: rd_data was taken |
| dat_valid | output | 1 | pulse: a data byte of a modify command arrived |
| dat_byte | output | 8 | that data byte |
| cmd_commit | output | 1 | pulse: modify command accepted |
| cmd_op | output | 8 | opcode of the current or last frame |
| cmd_addr | output | ADDR_W | address collected (also valid during reads) |
| cmd_len | output | LEN_W | count of data bytes in the committed command |

## Verification
The bench builds the block with three address bytes, a nine-bit length counter and two synchronizer stages. The serial clock half-period is eight block clocks, so each edge settles through the synchronizer well before the master samples. With these values, the dummy-byte alignment of both fast reads, an address frame cut short at a byte boundary, and reads stopped after a few bits are all reachable in a short run. The mid-byte and boundary chip-select releases are placed on exact edge counts, so the accept and reject decisions fall on the counted boundary itself.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam logic [7:0] OP_READ     = 8'h03;
    localparam logic [7:0] OP_FREAD    = 8'h0B;
    localparam logic [7:0] OP_DREAD    = 8'h3B;
    localparam logic [7:0] OP_RDSTAT   = 8'h05;
    localparam logic [7:0] OP_WRSTAT   = 8'h01;
    localparam logic [7:0] OP_WREN     = 8'h06;
    localparam logic [7:0] OP_WRDIS    = 8'h04;
    localparam logic [7:0] OP_PROG     = 8'h02;
    localparam logic [7:0] OP_ERASE_SS = 8'h20;
    localparam logic [7:0] OP_ERASE_S  = 8'hD8;
    localparam logic [7:0] OP_ERASE_B  = 8'hC7;
    localparam logic [7:0] OP_RDID     = 8'h9F;
    localparam logic [7:0] OP_SLEEP    = 8'hB9;
    localparam logic [7:0] OP_WAKE     = 8'hAB;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DUMMY,
        ST_RDATA,
        ST_WDATA,
        ST_IGNORE
    } fe_state_t;

    typedef struct packed {
        logic known;
        logic is_read;
        logic dual;
        logic array;
        logic has_addr;
        logic has_dummy;
    } op_info_t;

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              last;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= INIT;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= INIT;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last <= INIT;
        else        last <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign rise = q & ~last;
    assign fall = ~q & last;
endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
    import spi_fe_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    always_comb begin
        info       = '0;
        info.known = 1'b1;
        case (op)
            OP_READ: begin
                info.is_read  = 1'b1;
                info.array    = 1'b1;
                info.has_addr = 1'b1;
            end
            OP_FREAD: begin
                info.is_read   = 1'b1;
                info.array     = 1'b1;
                info.has_addr  = 1'b1;
                info.has_dummy = 1'b1;
            end
            OP_DREAD: begin
                info.is_read   = 1'b1;
                info.dual      = 1'b1;
                info.array     = 1'b1;
                info.has_addr  = 1'b1;
                info.has_dummy = 1'b1;
            end
            OP_RDSTAT, OP_RDID, OP_WAKE: info.is_read = 1'b1;
            OP_PROG, OP_ERASE_SS, OP_ERASE_S: begin
                info.array    = 1'b1;
                info.has_addr = 1'b1;
            end
            OP_ERASE_B: info.array = 1'b1;
            OP_WRSTAT, OP_WREN, OP_WRDIS, OP_SLEEP: info.known = 1'b1;
            default: info.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_fe_txshift.sv
module spi_fe_txshift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active,
    input  logic       shift_fall,
    input  logic       dual,
    input  logic [7:0] load_byte,
    output logic       dq1_o,
    output logic       dq0_o,
    output logic       oe,
    output logic       take
);
    logic [7:0] buf_q;
    logic [2:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= '0;
            cnt   <= '0;
            dq1_o <= 1'b0;
            dq0_o <= 1'b0;
            oe    <= 1'b0;
            take  <= 1'b0;
        end else if (!active) begin
            cnt   <= '0;
            oe    <= 1'b0;
            take  <= 1'b0;
            dq1_o <= 1'b0;
            dq0_o <= 1'b0;
        end else begin
            take <= 1'b0;
            if (shift_fall) begin
                oe <= 1'b1;
                if (cnt == 3'd0) begin
                    take  <= 1'b1;
                    dq1_o <= load_byte[7];
                    dq0_o <= load_byte[6];
                    buf_q <= dual ? (load_byte << 2) : (load_byte << 1);
                end else begin
                    dq1_o <= buf_q[7];
                    dq0_o <= buf_q[6];
                    buf_q <= dual ? (buf_q << 2) : (buf_q << 1);
                end
                cnt <= (dual && cnt == 3'd3) ? 3'd0 : cnt + 3'd1;
            end
        end
    end
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
    import spi_fe_pkg::*;
#(
    parameter  int ADDR_BYTES  = 3,
    parameter  int LEN_W       = 9,
    parameter  int SYNC_STAGES = 2,
    localparam int ADDR_W      = 8 * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              dq0_in,
    output logic              dq0_out,
    output logic              dq0_oe,
    output logic              dq1_out,
    output logic              dq1_oe,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic              rd_take,
    output logic              dat_valid,
    output logic [7:0]        dat_byte,
    output logic              cmd_commit,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [LEN_W-1:0]  cmd_len
);
    localparam int AC_W = $clog2(ADDR_BYTES + 1);
    localparam logic [AC_W-1:0] LAST_ADDR = AC_W'(ADDR_BYTES - 1);

    logic sck_s, sck_rise, sck_fall;
    logic cs_lvl, cs_rise, cs_fall;
    logic dq0_s, unused_dq_rise, unused_dq_fall;

    spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sck (
        .clk(clk), .rst_n(rst_n), .d(sck), .q(sck_s), .rise(sck_rise), .fall(sck_fall)
    );
    spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_cs (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_lvl), .rise(cs_rise), .fall(cs_fall)
    );
    spi_fe_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_dq (
        .clk(clk), .rst_n(rst_n), .d(dq0_in), .q(dq0_s), .rise(unused_dq_rise), .fall(unused_dq_fall)
    );

    fe_state_t        state_q, state_d;
    logic [2:0]       bit_cnt;
    logic [6:0]       sreg;
    logic [7:0]       new_byte;
    logic             byte_done;
    logic [7:0]       op_q;
    op_info_t         info_q, dec_now;
    logic [AC_W-1:0]  addr_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0] len_cnt;
    logic             unused_sck_lvl;

    assign unused_sck_lvl = sck_s;
    assign new_byte  = {sreg, dq0_s};
    assign byte_done = sck_rise && !cs_lvl && (bit_cnt == 3'd7);

    spi_fe_decode u_decode (.op(new_byte), .info(dec_now));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cs_fall) state_d = ST_OPCODE;
            end
            ST_OPCODE: begin
                if (byte_done) begin
                    if (!dec_now.known || (dec_now.array && busy)) state_d = ST_IGNORE;
                    else if (dec_now.has_addr)                     state_d = ST_ADDR;
                    else if (dec_now.is_read)                      state_d = ST_RDATA;
                    else                                           state_d = ST_WDATA;
                end
            end
            ST_ADDR: begin
                if (byte_done && addr_cnt == LAST_ADDR) begin
                    if (info_q.has_dummy)    state_d = ST_DUMMY;
                    else if (info_q.is_read) state_d = ST_RDATA;
                    else                     state_d = ST_WDATA;
                end
            end
            ST_DUMMY: begin
                if (byte_done) state_d = ST_RDATA;
            end
            ST_RDATA:  state_d = ST_RDATA;
            ST_WDATA:  state_d = ST_WDATA;
            ST_IGNORE: state_d = ST_IGNORE;
        endcase
        if (cs_rise) state_d = ST_IDLE;
    end

    // datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            sreg       <= '0;
            op_q       <= '0;
            info_q     <= '0;
            addr_cnt   <= '0;
            addr_q     <= '0;
            len_cnt    <= '0;
            dat_valid  <= 1'b0;
            dat_byte   <= '0;
            cmd_commit <= 1'b0;
            cmd_len    <= '0;
        end else begin
            cmd_commit <= 1'b0;
            dat_valid  <= 1'b0;
            if (cs_fall || cs_rise) begin
                bit_cnt <= '0;
            end else if (sck_rise && !cs_lvl) begin
                bit_cnt <= bit_cnt + 3'd1;
                sreg    <= {sreg[5:0], dq0_s};
            end
            if (cs_fall) begin
                len_cnt  <= '0;
                addr_cnt <= '0;
            end
            if (state_q == ST_OPCODE && byte_done) begin
                op_q   <= new_byte;
                info_q <= dec_now;
            end
            if (state_q == ST_ADDR && byte_done) begin
                addr_q   <= (addr_q << 8) | ADDR_W'(new_byte);
                addr_cnt <= addr_cnt + 1'b1;
            end
            if (state_q == ST_WDATA && byte_done) begin
                dat_valid <= 1'b1;
                dat_byte  <= new_byte;
                if (len_cnt != {LEN_W{1'b1}}) len_cnt <= len_cnt + 1'b1;
            end
            if (cs_rise && state_q == ST_WDATA && bit_cnt == 3'd0) begin
                cmd_commit <= 1'b1;
                cmd_len    <= len_cnt;
            end
        end
    end

    assign cmd_op   = op_q;
    assign cmd_addr = addr_q;

    logic tx_oe;

    spi_fe_txshift u_tx (
        .clk(clk), .rst_n(rst_n),
        .active(state_q == ST_RDATA),
        .shift_fall(sck_fall),
        .dual(info_q.dual),
        .load_byte(rd_data),
        .dq1_o(dq1_out), .dq0_o(dq0_out),
        .oe(tx_oe), .take(rd_take)
    );

    assign dq1_oe = tx_oe;
    assign dq0_oe = tx_oe & info_q.dual;
endmodule

// File: rtl/spi_cmd_frontend_chk.sv
module spi_cmd_frontend_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_lvl,
    input logic cmd_commit,
    input logic rd_take,
    input logic dat_valid,
    input logic dq1_oe,
    input logic dq0_oe
);
    // R6
    commit_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit |-> cs_lvl);
    // R6
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_commit |=> !cmd_commit);
    // R2
    oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq1_oe) |-> !cs_lvl);
    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_lvl) |=> ##1 !dq1_oe);
    // R2
    take_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |-> dq1_oe);
    // R3
    dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq0_oe |-> dq1_oe);
    // R8
    data_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dat_valid |-> !cs_lvl);
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_commit, rd_take, dat_valid}));
endmodule

bind spi_cmd_frontend spi_cmd_frontend_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl),
    .cmd_commit(cmd_commit), .rd_take(rd_take), .dat_valid(dat_valid),
    .dq1_oe(dq1_oe), .dq0_oe(dq0_oe)
);

// File: tb/spi_cmd_frontend_bench.sv
module spi_cmd_frontend_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int LW = 9;

    logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, dq0_in = 0, busy = 0;
    logic [7:0] rd_data = 8'h00;
    logic dq0_out, dq0_oe, dq1_out, dq1_oe, rd_take, dat_valid, cmd_commit;
    logic [7:0] dat_byte, cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [LW-1:0] cmd_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_frontend u_spi_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .dq0_in(dq0_in),
        .dq0_out(dq0_out), .dq0_oe(dq0_oe), .dq1_out(dq1_out), .dq1_oe(dq1_oe),
        .busy(busy), .rd_data(rd_data), .rd_take(rd_take),
        .dat_valid(dat_valid), .dat_byte(dat_byte),
        .cmd_commit(cmd_commit), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len)
    );

    typedef struct {
        logic [7:0]    op;
        logic [AW-1:0] addr;
        logic          use_addr;
        logic [LW-1:0] len;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0, bad = 0, commits = 0, dat_cnt = 0;
    logic [7:0] dat_last = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // monitor: commit scoreboard, data byte capture, read byte supply
    always @(negedge clk) begin
        if (rd_take) rd_data <= rd_data + 8'd1;
        if (dat_valid) begin
            dat_cnt++;
            dat_last = dat_byte;
        end
        if (cmd_commit) begin
            commits++;
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL R6/R7 unexpected commit actual=%0h expected=none", cmd_op);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (cmd_op !== e.op || cmd_len !== e.len || (e.use_addr && cmd_addr !== e.addr)) begin
                    bad++;
                    $display("FAIL R6 commit actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                             cmd_op, cmd_addr, cmd_len, e.op, e.addr, e.len);
                end
            end
        end
    end

    task automatic push_exp(input logic [7:0] op, input logic [AW-1:0] a, input logic ua, input logic [LW-1:0] len);
        exp_t e;
        e.op = op; e.addr = a; e.use_addr = ua; e.len = len;
        exp_q.push_back(e);
    endtask

    task automatic tick(input logic d, output logic o1, output logic o0, output logic oe1, output logic oe0);
        dq0_in = d;
        repeat (8) @(negedge clk);
        o1 = dq1_out; o0 = dq0_out; oe1 = dq1_oe; oe0 = dq0_oe;
        sck = 1'b1;
        repeat (8) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic frame_open();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic frame_close();
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (14) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic a, c, e, f;
        for (int i = 7; i > 7 - n; i--) tick(b[i], a, c, e, f);
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_bits(b, 8);
    endtask

    task automatic send_addr(input logic [AW-1:0] a);
        send_byte(a[23:16]); send_byte(a[15:8]); send_byte(a[7:0]);
    endtask

    // n single-line output bits; oe_all is 1 only if dq1_oe was high at every sample
    task automatic read_bits(input int n, output logic [7:0] v, output logic oe_all);
        logic o1, o0, e1, e0;
        v = 0; oe_all = 1;
        for (int i = 0; i < n; i++) begin
            tick(1'b0, o1, o0, e1, e0);
            v = {v[6:0], o1};
            oe_all = oe_all & e1;
        end
    endtask

    task automatic read_dual(output logic [7:0] v, output logic oe0_all);
        logic o1, o0, e1, e0;
        v = 0; oe0_all = 1;
        for (int i = 0; i < 4; i++) begin
            tick(1'b0, o1, o0, e1, e0);
            v = {v[5:0], o1, o0};
            oe0_all = oe0_all & e0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic oe;
        int c0;

        repeat (5) @(negedge clk);
        // R11 reset state
        check(dq1_oe === 0 && dq0_oe === 0, "R11 oe after reset", {dq1_oe, dq0_oe}, 0);
        check(cmd_commit === 0 && rd_take === 0 && dat_valid === 0, "R11 strobes after reset",
              {cmd_commit, rd_take, dat_valid}, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);

        // R6 write enable, no address
        push_exp(8'h06, '0, 0, 0);
        frame_open(); send_byte(8'h06); frame_close();
        check(exp_q.size() == 0, "R6 write enable commit", exp_q.size(), 0);

        // R1 R4 R6 sector erase with address
        push_exp(8'hD8, 24'h12A5C3, 1, 0);
        frame_open(); send_byte(8'hD8); send_addr(24'h12A5C3); frame_close();
        check(exp_q.size() == 0, "R1 sector erase address", exp_q.size(), 0);

        // R8 page program with three data bytes
        dat_cnt = 0;
        push_exp(8'h02, 24'h000100, 1, 3);
        frame_open(); send_byte(8'h02); send_addr(24'h000100);
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h9C); frame_close();
        check(exp_q.size() == 0, "R8 program commit", exp_q.size(), 0);
        check(dat_cnt == 3 && dat_last == 8'h9C, "R8 data bytes", {dat_cnt[7:0], dat_last}, {8'd3, 8'h9C});

        // R7 status write cut mid-byte
        c0 = commits;
        frame_open(); send_byte(8'h01); send_bits(8'hF0, 5); frame_close();
        check(commits == c0, "R7 status write mid-byte", commits - c0, 0);

        // R7 write enable plus three stray bits
        frame_open(); send_byte(8'h06); send_bits(8'hFF, 3); frame_close();
        check(commits == c0, "R7 write enable mid-byte", commits - c0, 0);

        // R6 erase with incomplete address ends on a byte boundary
        frame_open(); send_byte(8'h20); send_byte(8'h01); send_byte(8'h02); frame_close();
        check(commits == c0, "R6 incomplete address", commits - c0, 0);

        // R7 next frame after rejects commits normally
        push_exp(8'h04, '0, 0, 0);
        frame_open(); send_byte(8'h04); frame_close();
        check(exp_q.size() == 0, "R7 recover after reject", exp_q.size(), 0);

        // R2 plain read, two bytes
        rd_data = 8'hA5;
        frame_open(); send_byte(8'h03); send_addr(24'h00ABCD);
        read_bits(8, v, oe);
        check(v == 8'hA5 && oe, "R2 read byte 0", {oe, v}, {1'b1, 8'hA5});
        read_bits(8, v, oe);
        check(v == 8'hA6, "R2 read byte 1", v, 8'hA6);
        check(cmd_addr == 24'h00ABCD, "R1 read address", cmd_addr, 24'h00ABCD);
        frame_close();
        check(dq1_oe === 0, "R2 oe released", dq1_oe, 0);

        // R5 status read stopped after 3 bits, then complete
        rd_data = 8'hC3;
        frame_open(); send_byte(8'h05); read_bits(3, v, oe); frame_close();
        check(v[2:0] == 3'b110, "R5 partial status bits", v[2:0], 3'b110);
        rd_data = 8'h5E;
        frame_open(); send_byte(8'h05); read_bits(8, v, oe); frame_close();
        check(v == 8'h5E, "R5 status after partial", v, 8'h5E);

        // R4 fast read with dummy byte
        rd_data = 8'h3C;
        frame_open(); send_byte(8'h0B); send_addr(24'h010203); send_byte(8'h00);
        read_bits(8, v, oe); frame_close();
        check(v == 8'h3C && oe, "R4 fast read dummy", {oe, v}, {1'b1, 8'h3C});

        // R3 dual-output read
        rd_data = 8'hB4;
        frame_open(); send_byte(8'h3B); send_addr(24'h000010); send_byte(8'h00);
        read_dual(v, oe);
        check(v == 8'hB4, "R3 dual byte", v, 8'hB4);
        check(oe == 1, "R3 dq0 enable", oe, 1);
        frame_close();

        // R9 busy blocks array opcodes
        busy = 1;
        c0 = commits;
        frame_open(); send_byte(8'h03); send_addr(24'h000000);
        read_bits(8, v, oe); frame_close();
        check(oe == 0, "R9 read blocked while busy", oe, 0);
        frame_open(); send_byte(8'h02); send_addr(24'h000200); send_byte(8'h77); frame_close();
        frame_open(); send_byte(8'hC7); frame_close();
        check(commits == c0, "R9 program and erase blocked", commits - c0, 0);
        rd_data = 8'h81;
        frame_open(); send_byte(8'h05); read_bits(8, v, oe); frame_close();
        check(v == 8'h81 && oe, "R9 status read while busy", {oe, v}, {1'b1, 8'h81});
        push_exp(8'h06, '0, 0, 0);
        frame_open(); send_byte(8'h06); frame_close();
        check(exp_q.size() == 0, "R9 write enable while busy", exp_q.size(), 0);
        busy = 0;

        // R10 unknown opcode followed by a valid-looking byte
        c0 = commits;
        frame_open(); send_byte(8'h5A); send_byte(8'h06);
        read_bits(8, v, oe); frame_close();
        check(commits == c0 && oe == 0, "R10 unknown opcode ignored", {commits - c0, oe}, 0);

        // R6 bulk erase when idle
        push_exp(8'hC7, '0, 0, 0);
        frame_open(); send_byte(8'hC7); frame_close();
        check(exp_q.size() == 0, "R6 bulk erase commit", exp_q.size(), 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule